// File: doc/BRIEF.md
# Bridge deadlock retry timer controller

A bridge between a local bus and a PCI-style system bus can deadlock in one way. A local master's outbound cycle waits for the system bus. At the same moment, a system-bus master's inbound cycle waits for the local bus, which the first master holds. This block breaks that deadlock. It runs one countdown timer for each crossing direction. When a timer runs out, the block tells the owning side to let go and try again later. Retrying one side always favours the other.

The outbound timer runs only while its enable bit is set and a local-originated cycle is pending and blocked. When it expires, the block pulses a back-off request to the local master. The inbound timer runs while a system-originated cycle is pending. When it expires, the block pulses a target-retry indication to the system-bus master. Software sets both delays through a small register port, and so decides which side wins when both are waiting.

Top module: `bridge_retry_timer`

## Requirements
- R1: After reset, `local_backoff` and `target_retry` are low, and every register reads back zero.
- R2: Register map:
  - Address 0 holds the outbound delay, and address 1 holds the inbound delay. Both are DLY_W bits wide.
  - Address 2 holds the outbound enable in bit 0. Its other bits always read zero.
  - Address 3 always reads zero, and writes to it change nothing.
  - Each of addresses 0 to 2 reads back the last value written.
- R3: While the outbound enable is 0, `local_backoff` never asserts, however long an outbound cycle stays pending and blocked.
- R4: The outbound timer runs only while `ob_pending` and `ob_blocked` are both high (and the enable is set). A cycle in which either one is low reloads the timer from the outbound delay.
- R5: Counting from the first cycle in which the outbound condition holds, with outbound delay D, `local_backoff` is high in the clock cycle that follows the (D+1)-th consecutive rising edge with the condition true.
- R6: Each expiry gives a pulse exactly one cycle wide. No further pulse comes from that direction until its pending condition clears. After it clears, a fresh wait runs the full count again.
- R7: The inbound timer runs while `ib_pending` is high and reloads whenever it is low. With inbound delay D, `target_retry` pulses in the cycle after the (D+1)-th consecutive rising edge with `ib_pending` high.
- R8: A delay of zero produces the pulse after the first rising edge on which that side is seen waiting.
- R9: If both timers expire on the same edge, only `local_backoff` pulses. The inbound timer then reloads and needs a further D+1 pending edges before `target_retry` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ob_pending | input | 1 | A local-originated cycle to the system bus is pending |
| ob_blocked | input | 1 | That outbound cycle cannot get the system bus |
| ib_pending | input | 1 | A system-originated cycle to the local bus is pending |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DLY_W | Register write data |
| reg_rdata | output | DLY_W | Read data for `reg_addr` (combinational) |
| local_backoff | output | 1 | One-cycle request for the local master to release the bus and retry |
| target_retry | output | 1 | One-cycle target-retry indication to the system-bus master |

## Verification
Both timers can reach their terminal count on the same edge. That is the only case in which two retry decisions collide.

The bench provokes it by programming equal delays, enabling the outbound side, and raising both pending conditions on the same cycle. It then expects a lone `local_backoff` pulse at the shared expiry. A `target_retry` pulse must follow exactly one full inbound count later, with the inbound side still pending. A checker property also rules out the two outputs ever being high together.

// File: rtl/bridge_retry_timer.sv
module bridge_retry_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ob_pending,
  input  logic             ob_blocked,
  input  logic             ib_pending,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DLY_W-1:0] reg_wdata,
  output logic [DLY_W-1:0] reg_rdata,
  output logic             local_backoff,
  output logic             target_retry
);
  localparam logic [1:0] A_OB_DLY = 2'd0;
  localparam logic [1:0] A_IB_DLY = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;

  logic [DLY_W-1:0] ob_dly_q, ib_dly_q, ob_cnt_q, ib_cnt_q;
  logic ob_en_q, ob_done_q, ib_done_q;
  logic ob_live, ib_live, ob_fire, ib_hit, ib_fire;

  assign ob_live = ob_en_q & ob_pending & ob_blocked;
  assign ib_live = ib_pending;
  assign ob_fire = ob_live & ~ob_done_q & (ob_cnt_q == '0);
  assign ib_hit  = ib_live & ~ib_done_q & (ib_cnt_q == '0);
  assign ib_fire = ib_hit & ~ob_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_dly_q <= '0;
      ib_dly_q <= '0;
      ob_en_q  <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_OB_DLY: ob_dly_q <= reg_wdata;
        A_IB_DLY: ib_dly_q <= reg_wdata;
        A_CTRL:   ob_en_q  <= reg_wdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_OB_DLY: reg_rdata = ob_dly_q;
      A_IB_DLY: reg_rdata = ib_dly_q;
      A_CTRL:   reg_rdata[0] = ob_en_q;
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_cnt_q  <= '0;
      ob_done_q <= 1'b0;
    end else if (!ob_live) begin
      ob_cnt_q  <= ob_dly_q;
      ob_done_q <= 1'b0;
    end else if (ob_fire) begin
      ob_done_q <= 1'b1;
    end else if (!ob_done_q && ob_cnt_q != '0) begin
      ob_cnt_q <= ob_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ib_cnt_q  <= '0;
      ib_done_q <= 1'b0;
    end else if (!ib_live) begin
      ib_cnt_q  <= ib_dly_q;
      ib_done_q <= 1'b0;
    end else if (ib_hit && ob_fire) begin
      ib_cnt_q <= ib_dly_q;
    end else if (ib_fire) begin
      ib_done_q <= 1'b1;
    end else if (!ib_done_q && ib_cnt_q != '0) begin
      ib_cnt_q <= ib_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_backoff <= 1'b0;
      target_retry  <= 1'b0;
    end else begin
      local_backoff <= ob_fire;
      target_retry  <= ib_fire;
    end
  end
endmodule

module bridge_retry_timer_chk #(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ob_pending,
  input logic             ob_blocked,
  input logic             ib_pending,
  input logic             ob_en_q,
  input logic [1:0]       reg_addr,
  input logic [DLY_W-1:0] reg_rdata,
  input logic             local_backoff,
  input logic             target_retry
);
  p_never_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(local_backoff && target_retry));

  p_backoff_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    local_backoff |=> !local_backoff);

  p_retry_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    target_retry |=> !target_retry);

  p_backoff_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    local_backoff |-> $past(ob_en_q && ob_pending && ob_blocked));

  p_retry_needs_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    target_retry |-> $past(ib_pending));

  p_unused_addr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata == '0));
endmodule

bind bridge_retry_timer bridge_retry_timer_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ob_pending(ob_pending), .ob_blocked(ob_blocked),
  .ib_pending(ib_pending), .ob_en_q(ob_en_q), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .local_backoff(local_backoff), .target_retry(target_retry)
);

// File: tb/sim_bridge_retry_timer.sv
module sim_bridge_retry_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ob_pending = 1'b0, ob_blocked = 1'b0, ib_pending = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic local_backoff, target_retry;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [1:0] q_exp[$];
  string      q_tag[$];

  always #10 clk = ~clk;

  bridge_retry_timer #(.DLY_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ob_pending(ob_pending), .ob_blocked(ob_blocked),
    .ib_pending(ib_pending), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .local_backoff(local_backoff), .target_retry(target_retry)
  );

  // monitor: compares outputs a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_exp.size() > 0) begin
        logic [1:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        vectors++;
        if ({local_backoff, target_retry} !== e) begin
          fails++;
          $display("FAIL %s: backoff/retry=%b%b expected %b%b", t,
                   local_backoff, target_retry, e[1], e[0]);
        end
      end
    end
  end

  task automatic cyc(input logic op, input logic ob, input logic ip,
                     input logic ebo, input logic etr, input string tag);
    @(negedge clk);
    reg_wr = 1'b0;
    ob_pending = op; ob_blocked = ob; ib_pending = ip;
    q_exp.push_back({ebo, etr});
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    ob_pending = 1'b0; ob_blocked = 1'b0; ib_pending = 1'b0;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    q_exp.push_back(2'b00);
    q_tag.push_back("R2 write");
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    ob_pending = 1'b0; ob_blocked = 1'b0; ib_pending = 1'b0;
    q_exp.push_back(2'b00);
    q_tag.push_back(tag);
    #2;
    vectors++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata[%0d]=%h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "idle");
  endtask

  task automatic drain;
    while (q_exp.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_check(2'd0, '0, "R1");
    rd_check(2'd1, '0, "R1");
    rd_check(2'd2, '0, "R1");
    rd_check(2'd3, '0, "R1");

    // R2: register map and readback
    wr(2'd0, 16'd5);
    wr(2'd1, 16'd7);
    wr(2'd2, 16'hFFFE);
    wr(2'd3, 16'hABCD);
    rd_check(2'd0, 16'd5, "R2");
    rd_check(2'd1, 16'd7, "R2");
    rd_check(2'd2, 16'd0, "R2");
    rd_check(2'd3, 16'd0, "R2");
    idle(2);

    // R3: disabled outbound never backs off
    for (int i = 1; i <= 20; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    wr(2'd2, 16'h0001);
    rd_check(2'd2, 16'd1, "R2");
    idle(2);

    // R4: pending without blocked is not counted
    for (int i = 1; i <= 10; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    for (int i = 1; i <= 10; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4");

    // R5/R6: delay 5 expires after the 6th edge, one pulse, then holds
    for (int i = 1; i <= 14; i++) cyc(1'b1, 1'b1, 1'b0, i == 6, 1'b0, "R5_R6");
    idle(1);
    // R6: a fresh wait runs the full count
    for (int i = 1; i <= 9; i++) cyc(1'b1, 1'b1, 1'b0, i == 6, 1'b0, "R6");
    idle(1);

    // R4: a gap in blocked reloads the count
    for (int i = 1; i <= 4; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    for (int i = 1; i <= 8; i++) cyc(1'b1, 1'b1, 1'b0, i == 6, 1'b0, "R4");
    idle(1);

    // R7: inbound delay 7
    for (int i = 1; i <= 12; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, i == 8, "R7");
    idle(1);
    for (int i = 1; i <= 3; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    idle(1);
    for (int i = 1; i <= 9; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, i == 8, "R7");

    // R8: zero delays
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    idle(1);
    for (int i = 1; i <= 4; i++) cyc(1'b1, 1'b1, 1'b0, i == 1, 1'b0, "R8");
    idle(1);
    for (int i = 1; i <= 4; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, i == 1, "R8");
    idle(1);

    // R9: simultaneous expiry, outbound wins, inbound reloads
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd3);
    idle(1);
    for (int i = 1; i <= 12; i++) cyc(1'b1, 1'b1, 1'b1, i == 4, i == 8, "R9");
    idle(1);
    // R9 with zero delays: collision on the first edge, retry one edge later
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    idle(1);
    for (int i = 1; i <= 5; i++) cyc(1'b1, 1'b1, 1'b1, i == 1, i == 2, "R9");
    idle(2);

    drain();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule